// File: doc/BRIEF.md
# False-Sharing Memory Traffic Checker

This block drives random single-byte read and write traffic into a memory or cache under test and checks every read that comes back. Each cycle it may build one request. A 32-bit LFSR supplies the random choices. The address is a random offset inside a configured window. The offset's low six bits are replaced by the tester's identifier, so several instances with different identifiers each own one byte lane of every 64-byte line and share the lines themselves. This false sharing makes a coherent cache move the line back and forth between the testers.

The checker keeps a shadow byte array holding the contents it expects. Writes update the shadow when they are issued. A read captures the expected byte when it is issued, and that byte is compared with the returned data. Up to eight requests can be in flight, and each is identified by a tag that indexes an internal table. No new request goes to an address that already has a request outstanding. When the port refuses a request, the checker parks it and waits for a retry pulse. The checker stops issuing requests when any of these conditions occurs:
- a data mismatch,
- a long stretch without any response,
- the configured number of completed reads.

Top module: `fs_traffic_checker`

## Requirements
- R1: Every presented request has `req_addr[5:0]` equal to `TESTER_ID`. The rest of the address is a base plus an offset below `MEM_BYTES`.
- R2: `req_uncached` is 1 exactly when the base is `BASE_UC` (0x800000). Cacheable requests use `BASE_A` (0x100000) or `BASE_B` (0x400000).
- R3: At most `TAGS` (8) requests are in flight. No two requests in flight share a tag or an address. A new request is only generated for an address with nothing outstanding.
- R4: When a request is presented with `req_ready` low, `req_valid` is low from the next cycle on, and the address, data, write flag and tag do not change. The cycle after a `req_retry` pulse, the same request is presented again. No other request appears in the meantime.
- R5: A read response whose data equals the shadow value leaves `err_mismatch` at 0. Shadow values are the last byte written to that address, or 0 if the address was never written.
- R6: A read response whose data differs from the expected byte sets `err_mismatch` at the edge that takes the response. At the same edge, `err_addr` takes that request's address. Both hold until reset, and no further requests are generated.
- R7: `rd_count` and `wr_count` count completed reads and writes. A completion is visible right after the edge that takes its response. A response on a tag with nothing in flight changes neither count.
- R8: `done` rises at the same edge at which `rd_count` reaches `MAX_LOADS` and stays high. After that, no new requests are generated.
- R9: `err_deadlock` rises after `DEADLOCK_CYCLES` consecutive edges with `rsp_valid` low. Any response restarts the count. The flag is sticky and stops issue.
- R10: During reset, `req_valid`, `done`, both error flags, `err_addr` and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | output | 1 | Request is presented |
| req_ready | input | 1 | Port takes the presented request |
| req_retry | input | 1 | Pulse: re-present the refused request |
| req_addr | output | ADDR_W | Byte address |
| req_write | output | 1 | 1 = write, 0 = read |
| req_uncached | output | 1 | Access bypasses caches |
| req_wdata | output | 8 | Write byte |
| req_tag | output | TAG_W | In-flight table index |
| rsp_valid | input | 1 | Response is present |
| rsp_tag | input | TAG_W | Tag of the completed request |
| rsp_rdata | input | 8 | Read data returned |
| done | output | 1 | Read limit reached |
| err_mismatch | output | 1 | Read data differed from the shadow |
| err_addr | output | ADDR_W | Address of the first mismatch |
| err_deadlock | output | 1 | No response for too long |
| rd_count | output | CNT_W | Completed reads |
| wr_count | output | CNT_W | Completed writes |

## Verification
Every result is registered:
- The counters, `done` and `err_mismatch` change at the edge that takes a response.
- `req_valid` falls one edge after a refusal and returns one edge after a retry pulse.
- `err_deadlock` rises at the edge that completes the idle window.

The bench drives its inputs and samples the outputs at the falling edge. Before comparing, its behavioural model first applies the acceptances, responses, refusals and retries seen at the rising edge in between. This way every expected value is compared in exactly the cycle the result is due. The deadlock window is checked a few cycles before and after its limit as well as against the exact model.

// File: rtl/fs_chk_pkg.sv
`timescale 1ns/1ps
package fs_chk_pkg;

  // Galois taps for x^32 + x^22 + x^2 + x + 1 (right-shifting form)
  localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;

  // Shadow region selector; forms the top bits of the shadow index
  typedef enum logic [1:0] {
    RGN_A  = 2'd0,
    RGN_B  = 2'd1,
    RGN_UC = 2'd2
  } region_e;

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
  endfunction

endpackage

// File: rtl/fs_lfsr.sv
`timescale 1ns/1ps
module fs_lfsr
  import fs_chk_pkg::*;
#(
  parameter logic [31:0] SEED = 32'hACE1_2468
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] state
);

  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else     state <= lfsr_next(state);
  end

  a_r3_seed_nonzero: assert property (@(posedge clk) disable iff (rst)
    state != 32'd0);

endmodule

// File: rtl/fs_shadow_ram.sv
`timescale 1ns/1ps
module fs_shadow_ram #(
  parameter int unsigned IDX_W = 11,
  parameter int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       rdata
);

  logic [7:0] mem [DEPTH];

  // Power-up contents: all zero, as the memory under test starts
  initial begin
    for (int i = 0; i < int'(DEPTH); i++) mem[i] = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Distributed-RAM style asynchronous read
  assign rdata = mem[raddr];

endmodule

// File: rtl/fs_inflight_tbl.sv
`timescale 1ns/1ps
module fs_inflight_tbl #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned TAG_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit,
  output logic              full,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              alloc_en,
  input  logic              alloc_rd,
  input  logic [7:0]        alloc_exp,
  input  logic              free_en,
  input  logic [TAG_W-1:0]  free_tag,
  output logic              q_valid,
  output logic              q_rd,
  output logic [7:0]        q_exp,
  output logic [ADDR_W-1:0] q_addr
);

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] rd_q;
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [7:0]         exp_q  [ENTRIES];

  for (genvar gi = 0; gi < int'(ENTRIES); gi++) begin : g_cmp
    assign hit_vec[gi] = valid_q[gi] && (addr_q[gi] == look_addr);
  end

  assign hit  = |hit_vec;
  assign full = &valid_q;

  always_comb begin
    alloc_tag = '0;
    for (int i = int'(ENTRIES) - 1; i >= 0; i--)
      if (!valid_q[i]) alloc_tag = TAG_W'(i);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < int'(ENTRIES); i++) begin
      if (rst) begin
        valid_q[i] <= 1'b0;
      end else if (alloc_en && alloc_tag == TAG_W'(i)) begin
        valid_q[i] <= 1'b1;
      end else if (free_en && free_tag == TAG_W'(i)) begin
        valid_q[i] <= 1'b0;
      end
      if (alloc_en && alloc_tag == TAG_W'(i)) begin
        addr_q[i] <= look_addr;
        rd_q[i]   <= alloc_rd;
        exp_q[i]  <= alloc_exp;
      end
    end
  end

  assign q_valid = valid_q[free_tag];
  assign q_rd    = rd_q[free_tag];
  assign q_exp   = exp_q[free_tag];
  assign q_addr  = addr_q[free_tag];

  // R3: the caller only allocates for a fresh address into a free slot
  a_r3_alloc_fresh: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> (!hit && !full));
  a_r3_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    $countones(hit_vec) <= 1);

endmodule

// File: rtl/fs_traffic_checker.sv
`timescale 1ns/1ps
module fs_traffic_checker
  import fs_chk_pkg::*;
#(
  parameter int unsigned TESTER_ID       = 0,
  parameter int unsigned MEM_BYTES       = 512,
  parameter int unsigned PCT_READ        = 50,
  parameter int unsigned PCT_UNCACHED    = 10,
  parameter int unsigned MAX_LOADS       = 1000,
  parameter int unsigned DEADLOCK_CYCLES = 500000,
  parameter int unsigned ADDR_W          = 24,
  parameter int unsigned CNT_W           = 16,
  parameter int unsigned TAGS            = 8,
  parameter int unsigned TAG_W           = $clog2(TAGS),
  parameter logic [31:0] SEED            = 32'hACE1_2468,
  parameter logic [ADDR_W-1:0] BASE_A    = 24'h10_0000,
  parameter logic [ADDR_W-1:0] BASE_B    = 24'h40_0000,
  parameter logic [ADDR_W-1:0] BASE_UC   = 24'h80_0000
) (
  input  logic              clk,
  input  logic              rst,
  output logic              req_valid,
  input  logic              req_ready,
  input  logic              req_retry,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_write,
  output logic              req_uncached,
  output logic [7:0]        req_wdata,
  output logic [TAG_W-1:0]  req_tag,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_tag,
  input  logic [7:0]        rsp_rdata,
  output logic              done,
  output logic              err_mismatch,
  output logic [ADDR_W-1:0] err_addr,
  output logic              err_deadlock,
  output logic [CNT_W-1:0]  rd_count,
  output logic [CNT_W-1:0]  wr_count
);

  localparam int unsigned OFS_W  = $clog2(MEM_BYTES);
  localparam int unsigned LINE_W = OFS_W - 6;
  localparam int unsigned SH_W   = OFS_W + 2;
  localparam int unsigned IDLE_W = $clog2(DEADLOCK_CYCLES + 1);

  // ---------------- random source and candidate request ----------------
  logic [31:0] rnd;
  fs_lfsr #(.SEED(SEED)) u_rng (.clk(clk), .rst(rst), .state(rnd));

  logic [OFS_W-1:0]  lane_off;
  logic [6:0]        cmd_roll, uc_roll;
  logic              cand_rd, cand_uc;
  logic [7:0]        cand_wdata;
  region_e           cand_rgn;
  logic [ADDR_W-1:0] cand_base, cand_addr;
  logic [SH_W-1:0]   sh_idx;

  assign lane_off   = {rnd[15 +: LINE_W], 6'(TESTER_ID)};
  assign cmd_roll   = rnd[6:0] % 7'd100;
  assign uc_roll    = rnd[13:7] % 7'd100;
  assign cand_rd    = cmd_roll < 7'(PCT_READ);
  assign cand_uc    = uc_roll < 7'(PCT_UNCACHED);
  assign cand_wdata = rnd[31:24] ^ rnd[23:16];

  always_comb begin
    if (cand_uc) begin
      cand_rgn  = RGN_UC;
      cand_base = BASE_UC;
    end else if (rnd[14]) begin
      cand_rgn  = RGN_A;
      cand_base = BASE_A;
    end else begin
      cand_rgn  = RGN_B;
      cand_base = BASE_B;
    end
  end

  assign cand_addr = cand_base + ADDR_W'(lane_off);
  assign sh_idx    = {cand_rgn, lane_off};

  // ---------------- tables ----------------
  logic             tbl_hit, tbl_full, gen_ok;
  logic [TAG_W-1:0] new_tag;
  logic             tq_valid, tq_rd;
  logic [7:0]       tq_exp, sh_rdata;
  logic [ADDR_W-1:0] tq_addr;

  fs_shadow_ram #(.IDX_W(SH_W)) u_shadow (
    .clk(clk), .we(gen_ok && !cand_rd), .waddr(sh_idx), .wdata(cand_wdata),
    .raddr(sh_idx), .rdata(sh_rdata)
  );

  fs_inflight_tbl #(.ENTRIES(TAGS), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_tbl (
    .clk(clk), .rst(rst),
    .look_addr(cand_addr), .hit(tbl_hit), .full(tbl_full), .alloc_tag(new_tag),
    .alloc_en(gen_ok), .alloc_rd(cand_rd),
    .alloc_exp(cand_rd ? sh_rdata : cand_wdata),
    .free_en(rsp_valid), .free_tag(rsp_tag),
    .q_valid(tq_valid), .q_rd(tq_rd), .q_exp(tq_exp), .q_addr(tq_addr)
  );

  // ---------------- issue control ----------------
  logic hold_q, stop, can_gen;

  assign stop    = done || err_mismatch || err_deadlock;
  assign can_gen = !stop && !hold_q && (!req_valid || req_ready);
  assign gen_ok  = can_gen && !tbl_hit && !tbl_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid    <= 1'b0;
      hold_q       <= 1'b0;
      req_addr     <= '0;
      req_write    <= 1'b0;
      req_uncached <= 1'b0;
      req_wdata    <= '0;
      req_tag      <= '0;
    end else if (hold_q) begin
      if (req_retry) begin
        req_valid <= 1'b1;
        hold_q    <= 1'b0;
      end
    end else if (req_valid && !req_ready) begin
      req_valid <= 1'b0;
      hold_q    <= 1'b1;
    end else if (gen_ok) begin
      req_valid    <= 1'b1;
      req_addr     <= cand_addr;
      req_write    <= !cand_rd;
      req_uncached <= cand_uc;
      req_wdata    <= cand_rd ? 8'h00 : cand_wdata;
      req_tag      <= new_tag;
    end else begin
      req_valid <= 1'b0;
    end
  end

  // ---------------- response checking ----------------
  logic             rsp_live, rsp_bad;
  logic [CNT_W-1:0] rd_nxt;
  logic [IDLE_W-1:0] idle_q;

  assign rsp_live = rsp_valid && tq_valid;
  assign rsp_bad  = rsp_live && tq_rd && (rsp_rdata != tq_exp);
  assign rd_nxt   = rd_count + CNT_W'(rsp_live && tq_rd);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_count     <= '0;
      wr_count     <= '0;
      done         <= 1'b0;
      err_mismatch <= 1'b0;
      err_addr     <= '0;
      err_deadlock <= 1'b0;
      idle_q       <= '0;
    end else begin
      rd_count <= rd_nxt;
      if (rsp_live && !tq_rd) wr_count <= wr_count + 1'b1;
      done <= done || (rd_nxt >= CNT_W'(MAX_LOADS));
      if (rsp_bad && !err_mismatch) begin
        err_mismatch <= 1'b1;
        err_addr     <= tq_addr;
      end
      if (rsp_valid) begin
        idle_q <= '0;
      end else begin
        if (idle_q != IDLE_W'(DEADLOCK_CYCLES)) idle_q <= idle_q + 1'b1;
        if (idle_q == IDLE_W'(DEADLOCK_CYCLES - 1)) err_deadlock <= 1'b1;
      end
    end
  end

  // ---------------- assertions ----------------
  a_r1_lane_owned: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_addr[5:0] == 6'(TESTER_ID)));
  a_r2_uncached_base: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_uncached == (req_addr >= BASE_UC)));
  a_r4_refused_held: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (!req_valid && $stable(req_addr) &&
      $stable(req_wdata) && $stable(req_write) && $stable(req_tag)));
  a_r4_wait_retry: assert property (@(posedge clk) disable iff (rst)
    (hold_q && !req_retry) |=> !req_valid);
  a_r6_mismatch_sticky: assert property (@(posedge clk) disable iff (rst)
    err_mismatch |=> (err_mismatch && $stable(err_addr)));
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  a_r8_no_issue_after_done: assert property (@(posedge clk) disable iff (rst)
    (done && !hold_q && !req_valid) |=> !req_valid);
  a_r9_deadlock_sticky: assert property (@(posedge clk) disable iff (rst)
    err_deadlock |=> err_deadlock);

endmodule

// File: tb/fs_traffic_checker_tb_top.sv
`timescale 1ns/1ps
module fs_traffic_checker_tb_top;

  localparam int ID    = 5;
  localparam int MEMB  = 512;
  localparam int MAXL  = 40;
  localparam int LIMIT = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req_valid, req_ready, req_retry, req_write, req_uncached;
  logic [23:0] req_addr, err_addr;
  logic [7:0]  req_wdata, rsp_rdata;
  logic [2:0]  req_tag, rsp_tag;
  logic        rsp_valid, done, err_mismatch, err_deadlock;
  logic [15:0] rd_count, wr_count;

  fs_traffic_checker #(
    .TESTER_ID(ID), .MEM_BYTES(MEMB), .PCT_READ(50), .PCT_UNCACHED(25),
    .MAX_LOADS(MAXL), .DEADLOCK_CYCLES(LIMIT)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_retry(req_retry), .req_addr(req_addr), .req_write(req_write),
    .req_uncached(req_uncached), .req_wdata(req_wdata), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_rdata(rsp_rdata),
    .done(done), .err_mismatch(err_mismatch), .err_addr(err_addr),
    .err_deadlock(err_deadlock), .rd_count(rd_count), .wr_count(wr_count)
  );

  int n_chk = 0;
  int n_fail = 0;

  // behavioural model state
  logic [7:0] mem [int];
  bit   fv [8];
  int   fa [8];
  bit   fw [8];
  int   m_rd, m_wr, m_idle;
  bit   exp_mis, exp_dead, waiting, retried, corrupt_used;
  int   exp_eaddr;
  int   h_addr, h_tag, h_data;
  bit   h_write;
  // previous-cycle view
  bit   p_valid, p_ready, p_retry, p_rsp, p_corrupt, p_write;
  int   p_addr, p_tag, p_wdata, p_rtag;
  // stimulus modes
  int   rdy_pct;
  bit   resp_on, corrupt_mode, inject_idle;

  task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_rd(input int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic do_reset();
    rst = 1'b1; req_ready = 1'b0; req_retry = 1'b0;
    rsp_valid = 1'b0; rsp_tag = '0; rsp_rdata = '0;
    repeat (3) @(negedge clk);
    chk(!req_valid && !done && !err_mismatch && !err_deadlock && err_addr == 0 &&
        rd_count == 0 && wr_count == 0, "R10 reset outputs", {req_valid, done, err_mismatch, err_deadlock}, 0);
    for (int t = 0; t < 8; t++) fv[t] = 1'b0;
    m_rd = 0; m_wr = 0; m_idle = 0; exp_mis = 0; exp_dead = 0; waiting = 0;
    corrupt_used = 0; p_valid = 0; p_ready = 0; p_retry = 0; p_rsp = 0; p_corrupt = 0;
    rst = 1'b0;
  endtask

  task automatic step();
    bit found;
    int tk;
    @(negedge clk);
    // apply what the last rising edge saw
    if (p_valid && p_ready) begin
      chk(!fv[p_tag], "R3 tag reused while in flight", p_tag, -1);
      for (int t = 0; t < 8; t++)
        if (fv[t]) chk(fa[t] != p_addr, "R3 address already in flight", p_addr, fa[t]);
      fv[p_tag] = 1'b1; fa[p_tag] = p_addr; fw[p_tag] = p_write;
      if (p_write) mem[p_addr] = 8'(p_wdata);
    end
    if (p_rsp) begin
      m_idle = 0;
      if (fv[p_rtag]) begin
        if (fw[p_rtag]) m_wr++;
        else begin
          m_rd++;
          if (p_corrupt && !exp_mis) begin exp_mis = 1; exp_eaddr = fa[p_rtag]; end
        end
        fv[p_rtag] = 1'b0;
      end
    end else m_idle++;
    if (m_idle >= LIMIT) exp_dead = 1;
    retried = 0;
    if (waiting && p_retry) begin waiting = 0; retried = 1; end
    if (p_valid && !p_ready) begin
      waiting = 1; h_addr = p_addr; h_tag = p_tag; h_data = p_wdata; h_write = p_write;
    end
    // compare
    if (waiting) begin
      chk(!req_valid, "R4 no request while waiting for retry", req_valid, 0);
      chk(req_addr == 24'(h_addr) && req_tag == 3'(h_tag) && req_wdata == 8'(h_data) &&
          req_write == h_write, "R4 held request changed", req_addr, h_addr);
    end
    if (retried)
      chk(req_valid && req_addr == 24'(h_addr) && req_tag == 3'(h_tag) && req_wdata == 8'(h_data),
          "R4 request re-presented after retry", req_addr, h_addr);
    if (req_valid) begin
      chk(req_addr[5:0] == 6'(ID), "R1 byte lane", req_addr[5:0], ID);
      if (req_uncached)
        chk(req_addr >= 24'h80_0000 && req_addr < 24'h80_0000 + MEMB, "R2 uncached base", req_addr, 24'h80_0000);
      else
        chk((req_addr >= 24'h10_0000 && req_addr < 24'h10_0000 + MEMB) ||
            (req_addr >= 24'h40_0000 && req_addr < 24'h40_0000 + MEMB), "R2 cacheable base", req_addr, 24'h10_0000);
    end
    chk(rd_count == 16'(m_rd), "R7 read count", rd_count, m_rd);
    chk(wr_count == 16'(m_wr), "R7 write count", wr_count, m_wr);
    chk(done == (m_rd >= MAXL), "R8 done flag", done, m_rd >= MAXL);
    chk(err_mismatch == exp_mis, "R5 R6 mismatch flag", err_mismatch, exp_mis);
    if (exp_mis) chk(err_addr == 24'(exp_eaddr), "R6 error address", err_addr, exp_eaddr);
    chk(err_deadlock == exp_dead, "R9 deadlock flag", err_deadlock, exp_dead);
    // capture outputs and drive the next inputs
    p_valid = req_valid; p_addr = req_addr; p_tag = req_tag;
    p_wdata = req_wdata; p_write = req_write;
    req_ready = ($urandom_range(0, 99) < rdy_pct);
    req_retry = waiting && ($urandom_range(0, 2) == 0);
    rsp_valid = 1'b0; p_corrupt = 0; found = 0; tk = 0;
    if (inject_idle && !fv[3]) begin
      rsp_valid = 1'b1; rsp_tag = 3'd3; rsp_rdata = 8'hA5;
    end else if (resp_on && $urandom_range(0, 1) == 1) begin
      tk = $urandom_range(0, 7);
      for (int k = 0; k < 8; k++)
        if (!found && fv[(tk + k) % 8]) begin found = 1; tk = (tk + k) % 8; end
      if (found) begin
        rsp_valid = 1'b1; rsp_tag = 3'(tk);
        rsp_rdata = fw[tk] ? 8'($urandom) : mem_rd(fa[tk]);
        if (corrupt_mode && !fw[tk] && !corrupt_used) begin
          rsp_rdata = rsp_rdata ^ 8'h5A; p_corrupt = 1; corrupt_used = 1;
        end
      end
    end
    p_ready = req_ready; p_retry = req_retry; p_rsp = rsp_valid; p_rtag = rsp_tag;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    bit busy;
    rdy_pct = 70; resp_on = 1; corrupt_mode = 0; inject_idle = 0;
    // Phase 1: random traffic, refusals and retries, until the read limit
    do_reset();
    for (int i = 0; i < 6000 && m_rd < MAXL; i++) step();
    chk(done, "R8 done after read limit", done, 1);
    rdy_pct = 100;
    repeat (15) step();
    for (int i = 0; i < 30; i++) begin
      step();
      chk(!req_valid, "R8 no new request after done", req_valid, 0);
    end
    busy = 1;
    for (int i = 0; i < 400 && busy; i++) begin
      step();
      busy = 0;
      for (int t = 0; t < 8; t++) if (fv[t]) busy = 1;
    end
    // response on a tag with nothing in flight
    inject_idle = 1; step(); inject_idle = 0;
    step(); step();
    chk(rd_count == 16'(m_rd) && wr_count == 16'(m_wr), "R7 idle-tag response ignored", rd_count, m_rd);
    // Phase 2: one corrupted read response
    do_reset();
    corrupt_mode = 1;
    for (int i = 0; i < 3000 && !exp_mis; i++) step();
    chk(err_mismatch, "R6 mismatch detected", err_mismatch, 1);
    repeat (5) step();
    for (int i = 0; i < 20; i++) begin
      step();
      chk(!req_valid, "R6 issue stops after mismatch", req_valid, 0);
    end
    corrupt_mode = 0;
    // Phase 3: no responses at all
    do_reset();
    resp_on = 0;
    repeat (LIMIT - 3) step();
    chk(!err_deadlock, "R9 deadlock not yet due", err_deadlock, 0);
    chk(!req_valid, "R3 issue blocked with all tags in flight", req_valid, 0);
    repeat (6) step();
    chk(err_deadlock, "R9 deadlock raised", err_deadlock, 1);
    summary();
    $finish;
  end

endmodule